// File: doc/BRIEF.md
# Network controller register file

This block is the memory-mapped control and status register bank of a gigabit Ethernet controller model. A host reaches it through a simple 32-bit bus that carries a word address, a write strobe and a read strobe. The bank holds device control and status, the interrupt cause and mask, the split of a fixed 64-unit packet buffer between receive and transmit, the two receive flow-control thresholds, and a base, length, head and tail register set for each of the receive and transmit descriptor rings. Every register has a defined reset value.

Writes have side effects that a driver depends on. The interrupt cause can be replaced directly or OR-ed through a separate set alias. The mask can only be changed through set and clear aliases. Writing the receive buffer share hands the transmit side whatever is left of the 64 units. Ring base and length writes are forced to their alignment. Several addresses read as zero or ignore writes. Filter-table and statistics address windows return zero and hold no storage. Any other access to an unmapped address raises a sticky error output and a one-cycle pulse with the offending address captured.

Top module: `netctl_regs`

## Requirements
- R1: After reset, control reads 0x00000A09 (full duplex bit 0, link reset bit 3, speed field bits 9:8 = 2, force-speed bit 11), status reads 0x000000C1 (full duplex bit 0, speed field bits 7:6 = 3), buffer split reads 0x00100030, high flow threshold reads 1, low flow threshold, cause and mask read 0, and the error outputs are low.
- R2: Control (word 0x000), status (0x001), cause (0x004), low threshold (0x00C), high threshold (0x00D) and ring base-high, head and tail registers store the full written word; read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.
- R3: A write to the cause-set alias (0x005) ORs the written word into the cause register, read at 0x004.
- R4: A write to the mask-set alias (0x006) ORs the written word into the mask; a write to the mask-clear alias (0x007) clears every mask bit set in the written word; the mask reads back at either alias.
- R5: A write to the buffer split (0x008) sets the receive share, bits 15:0, from written bits 15:0 and the transmit share, bits 31:16, to 64 minus the receive share modulo 2^16; written bits 31:16 are ignored.
- R6: Ring base-low writes clear bits 3:0 and ring length writes clear bits 6:0. Receive ring words are 0x020 base-low, 0x021 base-high, 0x022 length, 0x023 head, 0x024 tail; transmit ring words are the same fields at 0x028 to 0x02C.
- R7: Wake-up control (0x010) and LED control (0x011) read zero and ignore writes; writes to the discard group 0x018 to 0x01D change no register.
- R8: Reads in the VLAN filter window (0x400-0x47F), receive address window (0x500-0x51F, two words per entry), multicast window (0x600-0x67F) and statistics window (0x800-0x83F) return zero without error; writes to the first three windows are accepted without error.
- R9: A read of an unmapped word, of the discard group or of the cause-set alias, and a write to an unmapped word or the statistics window, drives `err_pulse` high for the cycle after the access, loads `err_addr` with the address, and sets `err_sticky`, which stays high until reset.
- R10: The receive and transmit ring register sets are independent: a write to one never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 12 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle flag for an unmapped access |
| err_addr | output | 12 | Address of the last unmapped access |
| err_sticky | output | 1 | Unmapped access seen since reset |

## Verification
The bench aims at the write aliases: a cause-set that replaced instead of OR-ing would lose earlier bits, and a mask-clear that inverted or set bits would leave the cleared bits high on read-back. The buffer split is driven at a share of 32, exactly 64 (transmit must drop to zero), above 64 (transmit wraps to 0xFFF0) and with junk in the upper half, which a design that copied the whole word would reflect. Alignment is checked with all-ones writes to base-low and length, and a ring decode that aliased the two rings would show up as the transmit head overwriting the receive head. The error logic is tested on both directions, since a design that flagged by address alone would fault on zero-reading statistics reads or miss statistics writes, and the sticky flag is checked to outlive its pulse.

// File: rtl/netctl_pkg.sv
package netctl_pkg;

    localparam int DATA_W          = 32;
    localparam int ADDR_W          = 12;
    localparam int SHARE_W         = 16;
    localparam int BUF_UNITS       = 64;
    localparam int NUM_RINGS       = 2;
    localparam int RING_FIELDS     = 5;
    localparam int RING_IDX_W      = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1;
    localparam int BASE_ALIGN_BITS = 4;
    localparam int LEN_ALIGN_BITS  = 7;
    localparam int VLAN_WORDS      = 128;
    localparam int RXA_ENTRIES     = 16;
    localparam int RXA_WORDS       = RXA_ENTRIES * 2;
    localparam int MC_WORDS        = 128;
    localparam int STAT_WORDS      = 64;
    localparam int DISC_WORDS      = 6;

    localparam logic [ADDR_W-1:0] A_CTRL       = 12'h000;
    localparam logic [ADDR_W-1:0] A_STAT       = 12'h001;
    localparam logic [ADDR_W-1:0] A_CAUSE      = 12'h004;
    localparam logic [ADDR_W-1:0] A_CSET       = 12'h005;
    localparam logic [ADDR_W-1:0] A_MSET       = 12'h006;
    localparam logic [ADDR_W-1:0] A_MCLR       = 12'h007;
    localparam logic [ADDR_W-1:0] A_SPLIT      = 12'h008;
    localparam logic [ADDR_W-1:0] A_FCLO       = 12'h00C;
    localparam logic [ADDR_W-1:0] A_FCHI       = 12'h00D;
    localparam logic [ADDR_W-1:0] A_WAKE       = 12'h010;
    localparam logic [ADDR_W-1:0] A_LED        = 12'h011;
    localparam logic [ADDR_W-1:0] A_DISC_BASE  = 12'h018;
    localparam logic [ADDR_W-1:0] A_RING_BASE  = 12'h020;
    localparam logic [ADDR_W-1:0] A_RING_STEP  = 12'h008;
    localparam logic [ADDR_W-1:0] A_VLAN_BASE  = 12'h400;
    localparam logic [ADDR_W-1:0] A_RXA_BASE   = 12'h500;
    localparam logic [ADDR_W-1:0] A_MC_BASE    = 12'h600;
    localparam logic [ADDR_W-1:0] A_STATS_BASE = 12'h800;

    localparam logic [DATA_W-1:0]  CTRL_RST  = 32'h0000_0A09;
    localparam logic [DATA_W-1:0]  STAT_RST  = 32'h0000_00C1;
    localparam logic [DATA_W-1:0]  FCHI_RST  = 32'h0000_0001;
    localparam logic [SHARE_W-1:0] RX_SHARE_RST = 16'h0030;
    localparam logic [SHARE_W-1:0] BUF_TOTAL = SHARE_W'(BUF_UNITS);
    localparam logic [DATA_W-1:0]  BASE_KEEP = ~((DATA_W'(1) << BASE_ALIGN_BITS) - DATA_W'(1));
    localparam logic [DATA_W-1:0]  LEN_KEEP  = ~((DATA_W'(1) << LEN_ALIGN_BITS) - DATA_W'(1));

    typedef enum logic [3:0] {
        K_CTRL, K_STAT, K_CAUSE, K_CSET, K_MSET, K_MCLR, K_SPLIT,
        K_FCLO, K_FCHI, K_ZERO, K_DISCARD, K_RING, K_TABLE, K_STATS, K_NONE
    } acc_kind_e;

    typedef enum logic [2:0] {
        F_BASE_LO, F_BASE_HI, F_LEN, F_HEAD, F_TAIL
    } ring_fld_e;

    typedef struct packed {
        logic [DATA_W-1:0] base_lo;
        logic [DATA_W-1:0] base_hi;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] head;
        logic [DATA_W-1:0] tail;
    } ring_regs_t;

    typedef struct packed {
        logic [SHARE_W-1:0] tx;
        logic [SHARE_W-1:0] rx;
    } split_t;

    typedef struct packed {
        acc_kind_e             kind;
        logic [RING_IDX_W-1:0] ring_idx;
        ring_fld_e             fld;
    } decode_t;

    function automatic logic in_window(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base,
                                       int words);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + words);
    endfunction

    function automatic logic [ADDR_W-1:0] ring_start(int idx);
        return A_RING_BASE + ADDR_W'(idx) * A_RING_STEP;
    endfunction

endpackage

// File: rtl/netctl_decode.sv
module netctl_decode
    import netctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb begin
        dec.kind     = K_NONE;
        dec.ring_idx = '0;
        dec.fld      = F_BASE_LO;
        case (addr)
            A_CTRL:        dec.kind = K_CTRL;
            A_STAT:        dec.kind = K_STAT;
            A_CAUSE:       dec.kind = K_CAUSE;
            A_CSET:        dec.kind = K_CSET;
            A_MSET:        dec.kind = K_MSET;
            A_MCLR:        dec.kind = K_MCLR;
            A_SPLIT:       dec.kind = K_SPLIT;
            A_FCLO:        dec.kind = K_FCLO;
            A_FCHI:        dec.kind = K_FCHI;
            A_WAKE, A_LED: dec.kind = K_ZERO;
            default: begin
                if (in_window(addr, A_DISC_BASE, DISC_WORDS))
                    dec.kind = K_DISCARD;
                else if (in_window(addr, A_VLAN_BASE, VLAN_WORDS) ||
                         in_window(addr, A_RXA_BASE, RXA_WORDS) ||
                         in_window(addr, A_MC_BASE, MC_WORDS))
                    dec.kind = K_TABLE;
                else if (in_window(addr, A_STATS_BASE, STAT_WORDS))
                    dec.kind = K_STATS;
                for (int i = 0; i < NUM_RINGS; i++) begin
                    if (in_window(addr, ring_start(i), RING_FIELDS)) begin
                        dec.kind     = K_RING;
                        dec.ring_idx = RING_IDX_W'(i);
                        dec.fld      = ring_fld_e'(3'(addr - ring_start(i)));
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/netctl_ring.sv
module netctl_ring
    import netctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  ring_fld_e         fld,
    input  logic [DATA_W-1:0] wdata,
    output ring_regs_t        regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (fld)
                F_BASE_LO: regs.base_lo <= wdata & BASE_KEEP;
                F_BASE_HI: regs.base_hi <= wdata;
                F_LEN:     regs.len     <= wdata & LEN_KEEP;
                F_HEAD:    regs.head    <= wdata;
                F_TAIL:    regs.tail    <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/netctl_errtrk.sv
module netctl_errtrk
    import netctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bad,
    input  logic [ADDR_W-1:0] addr,
    output logic              pulse,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              sticky
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse    <= 1'b0;
            cap_addr <= '0;
            sticky   <= 1'b0;
        end else begin
            pulse <= bad;
            if (bad) begin
                cap_addr <= addr;
                sticky   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/netctl_regs.sv
module netctl_regs
    import netctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err_pulse,
    output logic [ADDR_W-1:0] err_addr,
    output logic              err_sticky
);
    decode_t           dec;
    logic [DATA_W-1:0] ctrl_q, stat_q, cause_q, mask_q, fclo_q, fchi_q;
    split_t            split_q;
    ring_regs_t        ring_q [NUM_RINGS];
    logic [DATA_W-1:0] rx_base_lo;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] ring_val;
    logic              rd_bad, wr_bad;

    netctl_decode u_dec (.addr(addr), .dec(dec));

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        netctl_ring u_ring (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en && dec.kind == K_RING && dec.ring_idx == RING_IDX_W'(g)),
            .fld   (dec.fld),
            .wdata (wdata),
            .regs  (ring_q[g])
        );
    end

    assign rx_base_lo = ring_q[0].base_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            stat_q   <= STAT_RST;
            cause_q  <= '0;
            mask_q   <= '0;
            split_q  <= '{tx: BUF_TOTAL - RX_SHARE_RST, rx: RX_SHARE_RST};
            fclo_q   <= '0;
            fchi_q   <= FCHI_RST;
        end else if (wr_en) begin
            case (dec.kind)
                K_CTRL:  ctrl_q  <= wdata;
                K_STAT:  stat_q  <= wdata;
                K_CAUSE: cause_q <= wdata;
                K_CSET:  cause_q <= cause_q | wdata;
                K_MSET:  mask_q  <= mask_q | wdata;
                K_MCLR:  mask_q  <= mask_q & ~wdata;
                K_SPLIT: split_q <= '{tx: BUF_TOTAL - wdata[SHARE_W-1:0],
                                      rx: wdata[SHARE_W-1:0]};
                K_FCLO:  fclo_q  <= wdata;
                K_FCHI:  fchi_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (dec.fld)
            F_BASE_LO: ring_val = ring_q[dec.ring_idx].base_lo;
            F_BASE_HI: ring_val = ring_q[dec.ring_idx].base_hi;
            F_LEN:     ring_val = ring_q[dec.ring_idx].len;
            F_HEAD:    ring_val = ring_q[dec.ring_idx].head;
            F_TAIL:    ring_val = ring_q[dec.ring_idx].tail;
            default:   ring_val = '0;
        endcase
    end

    always_comb begin
        case (dec.kind)
            K_CTRL:         rd_val = ctrl_q;
            K_STAT:         rd_val = stat_q;
            K_CAUSE:        rd_val = cause_q;
            K_MSET, K_MCLR: rd_val = mask_q;
            K_SPLIT:        rd_val = split_q;
            K_FCLO:         rd_val = fclo_q;
            K_FCHI:         rd_val = fchi_q;
            K_RING:         rd_val = ring_val;
            default:        rd_val = '0;
        endcase
    end

    assign rd_bad = (dec.kind == K_NONE) || (dec.kind == K_DISCARD) || (dec.kind == K_CSET);
    assign wr_bad = (dec.kind == K_NONE) || (dec.kind == K_STATS);

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    netctl_errtrk u_err (
        .clk      (clk),
        .rst      (rst),
        .bad      ((rd_en && rd_bad) || (wr_en && wr_bad)),
        .addr     (addr),
        .pulse    (err_pulse),
        .cap_addr (err_addr),
        .sticky   (err_sticky)
    );
endmodule

// File: rtl/netctl_regs_chk.sv
module netctl_regs_chk
    import netctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              err_pulse,
    input logic [ADDR_W-1:0] err_addr,
    input logic              err_sticky,
    input logic [DATA_W-1:0] cause_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] split_q,
    input logic [DATA_W-1:0] rx_base_lo
);
    assert_cause_set_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CSET) |=>
            ((cause_q & $past(wdata)) == $past(wdata)) &&
            ((cause_q & $past(cause_q)) == $past(cause_q)));

    assert_mask_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MCLR) |=> ((mask_q & $past(wdata)) == '0));

    assert_split_sum_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SPLIT) |=>
            (split_q[15:0] == $past(wdata[15:0])) &&
            (16'(split_q[31:16] + split_q[15:0]) == 16'(BUF_UNITS)));

    assert_base_align_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_RING_BASE) |=>
            (rx_base_lo[31:4] == $past(wdata[31:4])) && (rx_base_lo[3:0] == 4'h0));

    assert_stats_write_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= A_STATS_BASE && addr < A_STATS_BASE + ADDR_W'(STAT_WORDS)) |=>
            (err_pulse && err_addr == $past(addr)));

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    assert_pulse_sets_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky);
endmodule

bind netctl_regs netctl_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .err_pulse  (err_pulse),
    .err_addr   (err_addr),
    .err_sticky (err_sticky),
    .cause_q    (cause_q),
    .mask_q     (mask_q),
    .split_q    (split_q),
    .rx_base_lo (rx_base_lo)
);

// File: tb/netctl_regs_tb.sv
module netctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err_pulse, err_sticky;
    logic [11:0] err_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    netctl_regs u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err_pulse(err_pulse),
        .err_addr(err_addr), .err_sticky(err_sticky)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [11:0] waddr;
        logic [31:0] wval;
        logic [11:0] raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  12'h000, 32'h1234_5678, 12'h000, 32'h1234_5678}, // R2 control
        '{8'd2,  12'h001, 32'h0000_FFFF, 12'h001, 32'h0000_FFFF}, // R2 status
        '{8'd2,  12'h004, 32'h0000_000F, 12'h004, 32'h0000_000F}, // R2 cause direct
        '{8'd3,  12'h005, 32'h0000_0030, 12'h004, 32'h0000_003F}, // R3 set ORs
        '{8'd3,  12'h005, 32'h0000_0001, 12'h004, 32'h0000_003F}, // R3 overlap
        '{8'd4,  12'h006, 32'h0000_00F0, 12'h006, 32'h0000_00F0}, // R4 mask set
        '{8'd4,  12'h006, 32'h0000_000F, 12'h006, 32'h0000_00FF}, // R4 mask set ORs
        '{8'd4,  12'h007, 32'h0000_003C, 12'h007, 32'h0000_00C3}, // R4 mask clear
        '{8'd5,  12'h008, 32'h0000_0020, 12'h008, 32'h0020_0020}, // R5 half split
        '{8'd5,  12'h008, 32'h0000_0040, 12'h008, 32'h0000_0040}, // R5 all to rx
        '{8'd5,  12'h008, 32'h0000_0050, 12'h008, 32'hFFF0_0050}, // R5 wrap
        '{8'd5,  12'h008, 32'hABCD_0010, 12'h008, 32'h0030_0010}, // R5 upper ignored
        '{8'd6,  12'h020, 32'hFFFF_FFFF, 12'h020, 32'hFFFF_FFF0}, // R6 rx base low
        '{8'd6,  12'h022, 32'hFFFF_FFFF, 12'h022, 32'hFFFF_FF80}, // R6 rx length
        '{8'd6,  12'h02A, 32'h0000_FFFF, 12'h02A, 32'h0000_FF80}, // R6 tx length
        '{8'd6,  12'h028, 32'h1234_5678, 12'h028, 32'h1234_5670}, // R6 tx base low
        '{8'd2,  12'h021, 32'hDEAD_BEEF, 12'h021, 32'hDEAD_BEEF}, // R2 base high
        '{8'd2,  12'h023, 32'h0000_0011, 12'h023, 32'h0000_0011}, // R2 rx head
        '{8'd10, 12'h02B, 32'h0000_0033, 12'h023, 32'h0000_0011}, // R10 tx head vs rx
        '{8'd10, 12'h02C, 32'h0000_0044, 12'h024, 32'h0000_0000}, // R10 tx tail vs rx
        '{8'd7,  12'h010, 32'hFFFF_FFFF, 12'h010, 32'h0000_0000}, // R7 wake
        '{8'd7,  12'h011, 32'hFFFF_FFFF, 12'h011, 32'h0000_0000}, // R7 LED
        '{8'd7,  12'h018, 32'hFFFF_FFFF, 12'h000, 32'h1234_5678}, // R7 discard
        '{8'd8,  12'h400, 32'hFFFF_FFFF, 12'h47F, 32'h0000_0000}, // R8 VLAN
        '{8'd8,  12'h501, 32'hFFFF_FFFF, 12'h51F, 32'h0000_0000}, // R8 rx address
        '{8'd8,  12'h67F, 32'hFFFF_FFFF, 12'h600, 32'h0000_0000}  // R8 multicast
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        check("R1 err_sticky", {31'd0, err_sticky}, 32'd0);
        check("R1 err_pulse", {31'd0, err_pulse}, 32'd0);
        rd(12'h000); check("R1 control", rdata, 32'h0000_0A09);
        rd(12'h001); check("R1 status", rdata, 32'h0000_00C1);
        rd(12'h008); check("R1 split", rdata, 32'h0010_0030);
        rd(12'h00D); check("R1 high threshold", rdata, 32'h0000_0001);
        rd(12'h00C); check("R1 low threshold", rdata, 32'h0000_0000);
        rd(12'h004); check("R1 cause", rdata, 32'h0000_0000);
        rd(12'h006); check("R1 mask", rdata, 32'h0000_0000);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].waddr, VECS[i].wval);
            rd(VECS[i].raddr);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), rdata, VECS[i].exp);
        end

        // R2 thresholds and read data hold
        wr(12'h00C, 32'h0000_ABCD);
        wr(12'h00D, 32'h0000_1234);
        rd(12'h00C); check("R2 low threshold", rdata, 32'h0000_ABCD);
        rd(12'h00D); check("R2 high threshold", rdata, 32'h0000_1234);
        @(negedge clk); check("R2 rdata holds", rdata, 32'h0000_1234);

        // R8 no error from table traffic; statistics reads zero
        check("R8 no error after tables", {31'd0, err_sticky}, 32'd0);
        rd(12'h83F); check("R8 stats read", rdata, 32'h0000_0000);
        check("R8 stats read no error", {31'd0, err_pulse}, 32'd0);

        // R9 statistics write is flagged
        wr(12'h810, 32'h1);
        check("R9 stats write pulse", {31'd0, err_pulse}, 32'd1);
        check("R9 stats write addr", {20'd0, err_addr}, 32'h810);
        check("R9 sticky set", {31'd0, err_sticky}, 32'd1);
        @(negedge clk);
        check("R9 pulse drops", {31'd0, err_pulse}, 32'd0);
        check("R9 sticky holds", {31'd0, err_sticky}, 32'd1);

        // R9 discard-group read, unmapped read and write
        rd(12'h019);
        check("R9 discard read pulse", {31'd0, err_pulse}, 32'd1);
        check("R9 discard read addr", {20'd0, err_addr}, 32'h019);
        rd(12'h3FF);
        check("R9 unmapped read addr", {20'd0, err_addr}, 32'h3FF);
        wr(12'h0FF, 32'hFFFF_FFFF);
        check("R9 unmapped write pulse", {31'd0, err_pulse}, 32'd1);
        check("R9 unmapped write addr", {20'd0, err_addr}, 32'h0FF);
        rd(12'h000); check("R9 unmapped write no effect", rdata, 32'h1234_5678);

        // R1 reset clears error state again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 sticky cleared", {31'd0, err_sticky}, 32'd0);
        rd(12'h004); check("R1 cause after reset", rdata, 32'h0000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule